// File: doc/BRIEF.md
# Frame-Synchronised Header Update Controller

This block is the control front end that decides when a newly written display-list header address becomes the address the list executor runs from. Software writes a header address and reads back an update-pending bit, a field-status bit and the reference address in use. The block drives a one-cycle start request and the header address into the executor, and it raises a one-cycle completion pulse at frame ends that close a run.

In continuous mode, a write that arrives while the executor is idle and nothing is waiting starts execution on the next cycle. A write that arrives while the executor is busy is held as a shadow. A pending bit stays set until the next frame end that is not flagged as a bottom field. At that frame end the shadow is handed over and execution of the new header begins. In single-shot mode every write starts one run at once, and every frame end counts as completion.

Top module: `hdr_update_ctrl`

## Requirements
- R1: In continuous mode (`single_shot`=0), a write with `exec_busy`=0 and `upd_pending`=0 produces, one cycle later, `exec_start`=1 for exactly one cycle and `hdr_ref_addr` equal to the written address, with `upd_pending` staying 0.
- R2: In continuous mode, a write while `exec_busy`=1 and no frame end in the same cycle leaves `hdr_ref_addr` unchanged and does not assert `exec_start`.
- R3: `upd_pending` reads 1 from the cycle after a shadowed write until the cycle after the address is handed over, and then reads 0.
- R4: In continuous mode, a `frame_end` pulse with `field_bottom`=0 while an update is pending, or in the same cycle as a shadowed write, makes the next cycle show `hdr_ref_addr` equal to the newest written address, `exec_start`=1 and `frame_done`=1.
- R5: A `frame_end` with `field_bottom`=1 never hands over; `upd_pending` and `hdr_ref_addr` are unchanged after it. `field_status` shows the `field_bottom` value sampled at the most recent frame end (1 means bottom field).
- R6: In single-shot mode (`single_shot`=1), every write starts a run one cycle later (`exec_start`=1, `hdr_ref_addr` = written address, `upd_pending`=0) whatever `exec_busy` is, and every `frame_end` gives `frame_done`=1 one cycle later, whatever the field.
- R7: A write in continuous mode while `upd_pending`=1 replaces the shadow and keeps `upd_pending` at 1, even when `exec_busy`=0; only the last such address is handed over.
- R8: While `rst_n`=0 at a clock edge, `upd_pending`, `hdr_ref_addr`, `field_status`, `exec_start` and `frame_done` all become 0, and the engine counts as idle with nothing pending.
- R9: In continuous mode, a frame end with nothing pending and no write produces neither `exec_start` nor `frame_done` and leaves `hdr_ref_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| single_shot | input | 1 | 1 = single-shot mode, 0 = continuous mode |
| hdr_wr_en | input | 1 | One-cycle write strobe for the header address |
| hdr_wr_addr | input | ADDR_W | Header address being written |
| frame_end | input | 1 | One-cycle frame-end pulse |
| field_bottom | input | 1 | 1 when the ending field is a bottom field |
| exec_busy | input | 1 | Executor is running a list |
| exec_start | output | 1 | One-cycle start request to the executor |
| hdr_ref_addr | output | ADDR_W | Header address currently executed (readable) |
| upd_pending | output | 1 | Shadowed header waiting for a frame end |
| field_status | output | 1 | Field sampled at the last frame end |
| frame_done | output | 1 | One-cycle completion pulse after a frame end |

## Verification
The bench targets the collisions in the update path. A frame end can land on a bottom field while an update is waiting: a design that ignores the field would swap addresses one frame early. A write can coincide with a qualifying frame end: a design that hands over the old shadow would run a stale header. A second write can arrive while the executor is idle but an update is already pending: a design that starts at once would race the earlier hand-over. Single-shot runs are checked with a busy executor and a bottom field, where a design that still shadowed would never start or never report completion.

// File: rtl/hdr_pkg.sv
// Package: shared types for the header update controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hdr_pkg;

    // Operating mode of the controller, decoded from a single input bit.
    typedef enum logic {
        MODE_CONT   = 1'b0,
        MODE_SINGLE = 1'b1
    } hdr_mode_e;

    // Decision taken in one cycle by the shadow stage.
    typedef struct packed {
        logic imm_start;   // start at once from the written address
        logic handover;    // take the shadow at this frame end
    } hdr_decision_t;

    function automatic hdr_mode_e to_mode(input logic bit_in);
        return bit_in ? MODE_SINGLE : MODE_CONT;
    endfunction

endpackage

// File: rtl/hdr_field_qual.sv
// Module: hdr_field_qual
// Samples the field indicator at each frame end and says whether the
// current frame end is allowed to hand a header over (top field only).
// Assumes: frame_end is a one-cycle pulse in the clk domain.
module hdr_field_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic field_bottom,
    output logic fe_qual,
    output logic field_status
);

    // Frame end that may carry a header hand-over.
    always_comb begin
        fe_qual = frame_end && !field_bottom;
    end

    // Hold the field seen at the most recent frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_status <= 1'b0;
        end else if (frame_end) begin
            field_status <= field_bottom;
        end
    end

    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(field_status)) else $error("field status moved"); // R5

endmodule

// File: rtl/hdr_shadow_stage.sv
// Module: hdr_shadow_stage
// Owns the shadow address and the update-pending bit. Decides each cycle
// whether a write starts at once, is shadowed, or is handed over with a
// qualifying frame end. The newest address always wins.
// Assumes: in single-shot mode the caller only writes when it wants a run.
module hdr_shadow_stage
    import hdr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hdr_mode_e         mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              exec_busy,
    input  logic              fe_qual,
    output hdr_decision_t     dec,
    output logic [ADDR_W-1:0] hand_addr,
    output logic              pending
);

    logic [ADDR_W-1:0] shadow_q;
    logic              shadow_wr;

    // Classify the write and the frame end for this cycle.
    always_comb begin
        dec.imm_start = wr_en && ((mode == MODE_SINGLE) || (!exec_busy && !pending));
        shadow_wr     = wr_en && (mode == MODE_CONT) && !dec.imm_start;
        dec.handover  = (mode == MODE_CONT) && fe_qual && (pending || shadow_wr);
        hand_addr     = shadow_wr ? wr_addr : shadow_q;
    end

    // Shadow register: captures every write that cannot start at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (shadow_wr) begin
            shadow_q <= wr_addr;
        end
    end

    // Pending bit: set by a shadowed write, cleared on hand-over or single-shot write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (dec.handover || (wr_en && mode == MODE_SINGLE)) begin
            pending <= 1'b0;
        end else if (shadow_wr) begin
            pending <= 1'b1;
        end
    end

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CONT && pending && fe_qual) |=> !pending) else $error("pending kept"); // R3

    AST_PEND_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CONT && pending && wr_en && !fe_qual) |=> pending) else $error("pending lost"); // R7

    AST_NO_DUAL_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec.imm_start && dec.handover)) else $error("two starts"); // R4

endmodule

// File: rtl/hdr_ref_stage.sv
// Module: hdr_ref_stage
// Holds the reference address the executor runs from, and issues the
// start request and the completion pulse one cycle after the decision.
// Assumes: imm_start and handover are never high together.
module hdr_ref_stage
    import hdr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hdr_mode_e         mode,
    input  hdr_decision_t     dec,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] hand_addr,
    input  logic              frame_end,
    output logic [ADDR_W-1:0] ref_addr,
    output logic              start,
    output logic              done
);

    // Reference address: loaded by an immediate start or a hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_addr <= '0;
        end else if (dec.imm_start) begin
            ref_addr <= wr_addr;
        end else if (dec.handover) begin
            ref_addr <= hand_addr;
        end
    end

    // Start request and completion pulses, each one cycle wide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start <= 1'b0;
            done  <= 1'b0;
        end else begin
            start <= dec.imm_start || dec.handover;
            done  <= frame_end && ((mode == MODE_SINGLE) || dec.handover);
        end
    end

    AST_REF_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> $stable(ref_addr)) else $error("ref moved without start"); // R2

    AST_SS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SINGLE && frame_end) |=> done) else $error("single-shot done missing"); // R6

endmodule

// File: rtl/hdr_update_ctrl.sv
// Module: hdr_update_ctrl (top)
// Decides when a written header address takes effect: at once when the
// executor is idle, otherwise at the next top-field frame end; in
// single-shot mode every write starts a run.
// Assumes: all inputs synchronous to clk; frame_end and hdr_wr_en are pulses.
module hdr_update_ctrl
    import hdr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_shot,
    input  logic              hdr_wr_en,
    input  logic [ADDR_W-1:0] hdr_wr_addr,
    input  logic              frame_end,
    input  logic              field_bottom,
    input  logic              exec_busy,
    output logic              exec_start,
    output logic [ADDR_W-1:0] hdr_ref_addr,
    output logic              upd_pending,
    output logic              field_status,
    output logic              frame_done
);

    hdr_mode_e         mode;
    hdr_decision_t     dec;
    logic              fe_qual;
    logic [ADDR_W-1:0] hand_addr;

    // Decode the mode bit into the shared enum.
    always_comb begin
        mode = to_mode(single_shot);
    end

    hdr_field_qual u_field (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_end    (frame_end),
        .field_bottom (field_bottom),
        .fe_qual      (fe_qual),
        .field_status (field_status)
    );

    hdr_shadow_stage #(.ADDR_W(ADDR_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .wr_en     (hdr_wr_en),
        .wr_addr   (hdr_wr_addr),
        .exec_busy (exec_busy),
        .fe_qual   (fe_qual),
        .dec       (dec),
        .hand_addr (hand_addr),
        .pending   (upd_pending)
    );

    hdr_ref_stage #(.ADDR_W(ADDR_W)) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .dec       (dec),
        .wr_addr   (hdr_wr_addr),
        .hand_addr (hand_addr),
        .frame_end (frame_end),
        .ref_addr  (hdr_ref_addr),
        .start     (exec_start),
        .done      (frame_done)
    );

    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_shot && hdr_wr_en && !exec_busy && !upd_pending)
        |=> (exec_start && hdr_ref_addr == $past(hdr_wr_addr))) else $error("idle write no start"); // R1

    AST_BUSY_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_shot && hdr_wr_en && exec_busy && !frame_end)
        |=> (!exec_start && upd_pending)) else $error("busy write not shadowed"); // R2

    AST_BOTTOM_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_shot && upd_pending && frame_end && field_bottom)
        |=> (upd_pending && !exec_start)) else $error("bottom field handed over"); // R5

    AST_SS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (single_shot && hdr_wr_en) |=> (exec_start && !upd_pending)) else $error("single-shot no start"); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!upd_pending && hdr_ref_addr == '0 && !exec_start)) else $error("reset state"); // R8

endmodule

// File: tb/hdr_update_ctrl_tb_top.sv
module hdr_update_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic          ss;
        logic          wr;
        logic [AW-1:0] addr;
        logic          fe;
        logic          bot;
        logic          busy;
        logic          e_start;
        logic          e_pend;
        logic [AW-1:0] e_ref;
        logic          e_done;
        logic          e_fld;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        // ss   wr    addr      fe    bot   busy  start pend  ref       done  fld
        {1'b0, 1'b1, 16'h1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1000, 1'b0, 1'b0}, // R1
        {1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1000, 1'b0, 1'b0}, // R1 pulse ends
        {1'b0, 1'b1, 16'h2000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h1000, 1'b0, 1'b0}, // R2 R3
        {1'b0, 1'b1, 16'h3000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h1000, 1'b0, 1'b0}, // R7
        {1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h1000, 1'b0, 1'b1}, // R5
        {1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h3000, 1'b1, 1'b0}, // R4
        {1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h3000, 1'b0, 1'b0}, // R9
        {1'b0, 1'b1, 16'h4000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h4000, 1'b1, 1'b0}, // R4 same cycle
        {1'b1, 1'b1, 16'h5000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h5000, 1'b0, 1'b0}, // R6
        {1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h5000, 1'b1, 1'b1}  // R6
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          single_shot = 1'b0;
    logic          hdr_wr_en = 1'b0;
    logic [AW-1:0] hdr_wr_addr = '0;
    logic          frame_end = 1'b0;
    logic          field_bottom = 1'b0;
    logic          exec_busy = 1'b0;
    logic          exec_start;
    logic [AW-1:0] hdr_ref_addr;
    logic          upd_pending;
    logic          field_status;
    logic          frame_done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdr_update_ctrl #(.ADDR_W(AW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .single_shot  (single_shot),
        .hdr_wr_en    (hdr_wr_en),
        .hdr_wr_addr  (hdr_wr_addr),
        .frame_end    (frame_end),
        .field_bottom (field_bottom),
        .exec_busy    (exec_busy),
        .exec_start   (exec_start),
        .hdr_ref_addr (hdr_ref_addr),
        .upd_pending  (upd_pending),
        .field_status (field_status),
        .frame_done   (frame_done)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Apply inputs for one clock edge, then sample a quarter period after it.
    task automatic step(input logic ss, input logic wr, input logic [AW-1:0] a,
                        input logic fe, input logic bot, input logic busy);
        single_shot  = ss;
        hdr_wr_en    = wr;
        hdr_wr_addr  = a;
        frame_end    = fe;
        field_bottom = bot;
        exec_busy    = busy;
        @(posedge clk);
        #(CLK_PERIOD/4);
        hdr_wr_en = 1'b0;
        frame_end = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R8: state while held in reset
        @(posedge clk);
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R8", "pending", 32'(upd_pending), 32'h0);
        check("R8", "ref", 32'(hdr_ref_addr), 32'h0);
        check("R8", "start", 32'(exec_start), 32'h0);
        rst_n = 1'b1;

        // Table walk: each row is one clock with its expected outputs.
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].ss, VEC[i].wr, VEC[i].addr, VEC[i].fe, VEC[i].bot, VEC[i].busy);
            check($sformatf("R1-table row%0d", i), "start", 32'(exec_start), 32'(VEC[i].e_start));
            check($sformatf("R3-table row%0d", i), "pending", 32'(upd_pending), 32'(VEC[i].e_pend));
            check($sformatf("R4-table row%0d", i), "ref", 32'(hdr_ref_addr), 32'(VEC[i].e_ref));
            check($sformatf("R6-table row%0d", i), "done", 32'(frame_done), 32'(VEC[i].e_done));
            check($sformatf("R5-table row%0d", i), "field", 32'(field_status), 32'(VEC[i].e_fld));
        end

        // R7: idle write while pending is shadowed, newest wins
        step(1'b0, 1'b1, 16'h6000, 1'b0, 1'b0, 1'b1);
        check("R7", "pending after busy write", 32'(upd_pending), 32'h1);
        step(1'b0, 1'b1, 16'h7000, 1'b0, 1'b0, 1'b0);
        check("R7", "no start on idle write while pending", 32'(exec_start), 32'h0);
        check("R7", "ref held", 32'(hdr_ref_addr), 32'h5000);
        check("R7", "pending kept", 32'(upd_pending), 32'h1);
        step(1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0);
        check("R7", "newest shadow handed over", 32'(hdr_ref_addr), 32'h7000);
        check("R3", "pending cleared after hand-over", 32'(upd_pending), 32'h0);
        step(1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1);
        check("R4", "start is one cycle", 32'(exec_start), 32'h0);

        // R8: reset in the middle of a pending update
        step(1'b0, 1'b1, 16'h8000, 1'b1, 1'b1, 1'b1);
        check("R8", "pending before reset", 32'(upd_pending), 32'h1);
        rst_n = 1'b0;
        step(1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
        check("R8", "pending cleared", 32'(upd_pending), 32'h0);
        check("R8", "ref cleared", 32'(hdr_ref_addr), 32'h0);
        check("R8", "field cleared", 32'(field_status), 32'h0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0);
        check("R8", "shadow dropped: no hand-over", 32'(exec_start), 32'h0);
        check("R9", "no done with nothing pending", 32'(frame_done), 32'h0);
        step(1'b0, 1'b1, 16'h9000, 1'b0, 1'b0, 1'b0);
        check("R8", "idle after reset: immediate start", 32'(exec_start), 32'h1);
        check("R1", "ref after start", 32'(hdr_ref_addr), 32'h9000);

        finish_run();
    end

endmodule